// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit charge-redistribution successive-approximation converter. It drives a binary-weighted capacitor array through one switch-select field per capacitor, plus one switch that ties the shared top plates to the mid-rail reference. It reads a latched comparator and builds the result word. A start request begins a conversion. The conversion spends one clock capturing the input and then one clock per bit resolving it. When it ends, the sequencer returns to an idle state that presents the result word and a one-cycle done strobe.

The capture clock has two halves. While the clock is high, every bottom plate selects the input and the top plates are held at mid-rail. On the falling edge, every bottom plate moves to mid-rail and the top-plate switch opens. This inverts the stored charge onto the top node.

After capture, the capacitors are resolved one per rising edge, largest first. A high comparator sends the capacitor's bottom plate to the supply reference, and a low comparator sends it to ground. That choice is held until the conversion ends, and each decision becomes the next result bit, MSB first.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, and whenever no conversion is running, every select field of `plate_sel` reads mid-rail (code 2'b00), `top_close` is 0 and `done` is 0. Before the first conversion, `result` is 0.
- R2: On the rising edge where a start is accepted, the capture cycle begins. For the high half of that clock, every field reads input (code 2'b01) and `top_close` is 1.
- R3: From the falling edge of the capture cycle, every field reads mid-rail and `top_close` is 0. No field reads input, and `top_close` is never 1, at any rising edge.
- R4: On each resolving edge, the selected capacitor's field becomes supply (2'b10) if `comp` was 1 just before the edge, or ground (2'b11) if it was 0. That field keeps its value until the conversion ends. Capacitors not yet resolved stay at mid-rail.
- R5: Capacitors are resolved one per rising edge, from field NBITS-1 (the largest weight, bits [2*NBITS-1:2*NBITS-2]) down to field 0. The first is resolved on the edge that ends the capture cycle.
- R6: Let the start be accepted at edge E0. Then `done` is high for exactly the one cycle after edge E0+NBITS+1. At that same edge, `result` takes the comparator decisions, the first decision in the MSB. `result` holds until the next conversion ends, and all fields return to mid-rail.
- R7: A start that is asserted while a conversion is running is ignored: the running conversion's selects and timing are unchanged.
- R8: With an ideal array, the full-scale input range is 0..511 units, with supply at 512 units and mid-rail at 256 units. In that case the result equals 0 for input 0 and (input-1)/2 (rounded down) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its high and low halves split the capture cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, taken only while idle |
| comp | input | 1 | Latched comparator output, 1 when the top node is below mid-rail |
| plate_sel | output | 2*NBITS | Per-capacitor bottom-plate source; field i at bits [2i+1:2i] |
| top_close | output | 1 | 1 ties the top plates to mid-rail |
| result | output | NBITS | Last conversion result |
| done | output | 1 | One-cycle strobe when `result` updates |

## Verification
The properties assume that `comp` is stable around each rising edge, as a latched comparator provides. They also assume that `start` changes only away from the rising edge. The bench drives `start` and the input value on falling edges. Its ideal array model recomputes `comp` a short time after each falling edge from the current select fields, so the comparator never moves near a rising edge. Every input code in the full range is converted. On some codes, `start` is held high through the whole conversion, which exercises the busy case.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SEL_MID = 2'b00,
    SEL_IN  = 2'b01,
    SEL_HI  = 2'b10,
    SEL_LO  = 2'b11
  } plate_src_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SAMPLE = 2'b01,
    ST_CONV   = 2'b10
  } ctrl_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output ctrl_state_e     state,
  output logic            dec_en,
  output logic [IDXW-1:0] dec_idx,
  output logic            finish
);
  logic [IDXW-1:0] ptr_q;

  always_comb begin
    dec_en  = (state == ST_SAMPLE) || ((state == ST_CONV) && (ptr_q != '0));
    dec_idx = (state == ST_SAMPLE) ? IDXW'(NBITS - 1) : (ptr_q - 1'b1);
    finish  = (state == ST_CONV) && (ptr_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (start) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          state <= ST_CONV;
          ptr_q <= IDXW'(NBITS - 1);
        end
        ST_CONV: begin
          if (ptr_q != '0) ptr_q <= ptr_q - 1'b1;
          else             state <= ST_IDLE;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_plate_bank.sv
module sar_plate_bank
  import sar_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               dec_en,
  input  logic [IDXW-1:0]    dec_idx,
  input  logic               comp,
  output logic [2*NBITS-1:0] plate_q,
  output logic [NBITS-1:0]   bits_q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        plate_q[2*i +: 2] <= SEL_MID;
      end else if (dec_en && (dec_idx == IDXW'(i))) begin
        plate_q[2*i +: 2] <= comp ? SEL_HI : SEL_LO;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bits_q[i] <= 1'b0;
      end else if (dec_en && (dec_idx == IDXW'(i))) begin
        bits_q[i] <= comp;
      end
    end
  end
endmodule

// File: rtl/sar_phase.sv
module sar_phase
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampling,
  input  logic [2*NBITS-1:0] plate_q,
  output logic [2*NBITS-1:0] plate_sel,
  output logic               top_close
);
  logic inv_q;

  always_ff @(negedge clk) begin
    if (rst) inv_q <= 1'b0;
    else     inv_q <= sampling;
  end

  logic track;
  assign track = sampling && !inv_q;

  always_comb begin
    top_close = track;
    for (int i = 0; i < NBITS; i++) begin
      plate_sel[2*i +: 2] = track ? SEL_IN : plate_q[2*i +: 2];
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               comp,
  output logic [2*NBITS-1:0] plate_sel,
  output logic               top_close,
  output logic [NBITS-1:0]   result,
  output logic               done
);
  ctrl_state_e        state;
  logic               dec_en;
  logic [IDXW-1:0]    dec_idx;
  logic               finish;
  logic [2*NBITS-1:0] plate_q;
  logic [NBITS-1:0]   bits_q;
  logic               idle;

  assign idle = (state == ST_IDLE);

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .state(state),
    .dec_en(dec_en), .dec_idx(dec_idx), .finish(finish)
  );

  sar_plate_bank #(.NBITS(NBITS)) u_bank (
    .clk(clk), .rst(rst), .clear(finish), .dec_en(dec_en),
    .dec_idx(dec_idx), .comp(comp), .plate_q(plate_q), .bits_q(bits_q)
  );

  sar_phase #(.NBITS(NBITS)) u_phase (
    .clk(clk), .rst(rst), .sampling(state == ST_SAMPLE),
    .plate_q(plate_q), .plate_sel(plate_sel), .top_close(top_close)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) result <= bits_q;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int NBITS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               idle,
  input logic [2*NBITS-1:0] plate_sel,
  input logic               top_close,
  input logic               done
);
  localparam int CW = $clog2(NBITS + 4);

  logic [2*NBITS-1:0] prev_sel;
  logic [NBITS-1:0]   newly;
  logic [CW-1:0]      span;

  always_ff @(posedge clk) begin
    if (rst) prev_sel <= '0;
    else     prev_sel <= plate_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)               span <= '0;
    else if (done)         span <= '0;
    else if (span != '0)   span <= span + 1'b1;
    else if (start && idle) span <= CW'(1);
  end

  always_comb begin
    for (int i = 0; i < NBITS; i++) begin
      newly[i] = plate_sel[2*i+1] && (prev_sel[2*i +: 2] == 2'b00);
    end
  end

  AST_TOP_OPEN_AT_EDGE: assert property (@(posedge clk) disable iff (rst) !top_close); // R3
  AST_ONE_CAP_PER_EDGE: assert property (@(posedge clk) disable iff (rst) $onehot0(newly)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (span == CW'(NBITS + 2))); // R7

  for (genvar i = 0; i < NBITS; i++) begin : g_cap_chk
    AST_NO_INPUT_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
      plate_sel[2*i +: 2] != 2'b01); // R3
    AST_DECISION_HELD: assert property (@(posedge clk) disable iff (rst)
      plate_sel[2*i+1] |=> (done || (plate_sel[2*i +: 2] == $past(plate_sel[2*i +: 2])))); // R4
  end
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS)) i_chk (
  .clk(clk), .rst(rst), .start(start), .idle(idle),
  .plate_sel(plate_sel), .top_close(top_close), .done(done)
);

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;
  localparam int NBITS = 8;
  localparam int FULL  = 2 << NBITS;
  localparam int MID   = 1 << NBITS;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic               comp = 1'b0;
  logic [2*NBITS-1:0] plate_sel;
  logic               top_close;
  logic [NBITS-1:0]   result;
  logic               done;

  int n_vec = 0;
  int n_bad = 0;
  int vin_q = 0;

  always #5 clk = ~clk;

  sar_conv_ctrl #(.NBITS(NBITS)) i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .start(start), .comp(comp),
    .plate_sel(plate_sel), .top_close(top_close), .result(result), .done(done)
  );

  // ideal array: top node after inversion plus +/- weight per resolved plate
  always @(negedge clk) begin
    int vt;
    #2;
    vt = FULL - vin_q;
    for (int i = 0; i < NBITS; i++) begin
      if (plate_sel[2*i +: 2] == 2'b10) vt = vt + (1 << i);
      if (plate_sel[2*i +: 2] == 2'b11) vt = vt - (1 << i);
    end
    comp = (vt < MID);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_conv(input int vin, input bit hold_start);
    logic [NBITS-1:0]   bits;
    logic [2*NBITS-1:0] exp_sel;
    logic               c;
    int                 expc;
    @(negedge clk);
    vin_q = vin;
    start = 1'b1;
    @(posedge clk); #2;
    chk(plate_sel == {NBITS{2'b01}}, "R2 capture selects", plate_sel, {NBITS{2'b01}});
    chk(top_close == 1'b1, "R2 top closed", top_close, 1);
    if (!hold_start) start = 1'b0;
    @(negedge clk); #3;
    chk(plate_sel == '0, "R3 inversion selects", plate_sel, 0);
    chk(top_close == 1'b0, "R3 top open", top_close, 0);
    bits = '0;
    for (int k = NBITS - 1; k >= 0; k--) begin
      c = comp;
      @(posedge clk); #2;
      bits[k] = c;
      exp_sel = '0;
      for (int j = NBITS - 1; j >= k; j--) exp_sel[2*j +: 2] = bits[j] ? 2'b10 : 2'b11;
      chk(plate_sel == exp_sel, hold_start ? "R7 busy start ignored" : "R4 R5 resolve order",
          plate_sel, exp_sel);
      chk(done == 1'b0, "R6 no early done", done, 0);
      @(negedge clk); #3;
    end
    start = 1'b0;
    @(posedge clk); #2;
    expc = (vin == 0) ? 0 : (vin - 1) / 2;
    chk(done == 1'b1, "R6 done timing", done, 1);
    chk(result == bits, "R6 result bits", result, bits);
    chk(result == NBITS'(expc), "R8 conversion value", result, expc);
    @(posedge clk); #2;
    chk(done == 1'b0, "R6 done single", done, 0);
    chk(plate_sel == '0 && top_close == 1'b0, "R1 idle selects", plate_sel, 0);
    chk(result == bits, "R6 result held", result, bits);
  endtask

  initial begin
    #(200000 * 10);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk(plate_sel == '0, "R1 reset selects", plate_sel, 0);
    chk(top_close == 1'b0, "R1 reset top", top_close, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(result == '0, "R1 reset result", result, 0);
    for (int v = 0; v < FULL; v++) begin
      run_conv(v, (v % 7) == 3);
    end
    run_conv(FULL - 1, 1'b1);
    run_conv(0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule